// File: doc/BRIEF.md
# Level-Sensitive Interrupt Line Router

This block takes level-sensitive interrupt requests from four shared PCI interrupt pins and from up to seven on-chip functions, and steers each of them onto one of sixteen ISA-style IRQ lines. Each function brings its own 8-bit route number. The four pins take 4-bit route numbers from three configuration bytes. Several sources may share one line, and the line stays asserted while any of them is asserted.

Each source has a fixed source number: functions use their function number (1 to 7) and pins A to D use 8 to 11. A global mask holds the present level of every source. Each line has a mask of the sources routed to it. A change of a source level is an event. Events are handled one per clock, the lowest source number first. Each event updates the global mask. When the route is valid, it also sets or clears the source's bit in the target line's mask, and then ANDs that mask with the global mask, so bits left behind by an earlier route change are dropped. Disabled and illegal routes are discarded quietly.

Top module: `irq_router`

## Requirements
- R1: After reset every bit of `irq_out` is low and no source counts as asserted.
- R2: Pin A takes its route from bits [7:4] of `pin_rt_a`. Pin B takes it from bits [3:0] of `pin_rt_bc`, pin C from bits [7:4] of `pin_rt_bc`, and pin D from bits [7:4] of `pin_rt_d`. Pins A to D are source numbers 8 to 11.
- R3: Function n (1..7) is level `fn_lvl[n-1]`, takes its route from `fn_route[8n-1:8n-8]`, and is source number n.
- R4: A route of 0 or 0xFF is disabled. An event on such a route leaves every line unchanged, but the source's level is still recorded in the global mask.
- R5: A route of 2 is illegal and is dropped, and so is any route above 15. For functions 2, 3 and 5 the highest legal route is 14. Pins and the other functions may use 15.
- R6: A line is high while at least one source routed to it is asserted in that line's mask. Releasing one of two sharing sources keeps the line high.
- R7: On an event to a legal route, the target line's mask is ANDed with the updated global mask, so that bits of released sources left behind by a route change are removed.
- R8: A line that no event reaches keeps its state. A source that was rerouted and then released leaves its old line high until an event reaches that line.
- R9: Only one event is handled per clock, the lowest-numbered pending source first. The outputs are registered: the k-th event of a batch that appears at once shows on `irq_out` k cycles after the inputs change.
- R10: `irq_out[0]` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl | input | NUM_PINS (4) | Levels of PCI pins A..D, bit 0 = A |
| fn_lvl | input | NUM_FN (7) | Levels of functions 1..7, bit 0 = function 1 |
| fn_route | input | 8*NUM_FN | Route byte of each function, function n at bits [8n-1:8n-8] |
| pin_rt_a | input | 8 | Route byte holding pin A in [7:4] |
| pin_rt_bc | input | 8 | Route byte holding pin B in [3:0] and pin C in [7:4] |
| pin_rt_d | input | 8 | Route byte holding pin D in [7:4] |
| irq_out | output | NUM_LINES (16) | Registered IRQ line levels |

## Verification
When a single source changes at a falling edge, the result is due on `irq_out` after the next rising edge. The k-th of several simultaneous changes is due k rising edges later, in order of source number. The driver records each expected word together with its due cycle, counted in rising edges. The monitor compares only when the cycle count equals that due cycle, and it samples on falling edges. Route bytes are changed only while no event is pending, so every expectation depends only on the route in force when its event is handled.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int ROUTE_W = 8;
  typedef logic [ROUTE_W-1:0] route_t;

  // Legal target line: not disabled (0 / all ones), not the cascade line 2,
  // and no higher than the source's ceiling.
  function automatic logic route_usable(input route_t r, input logic narrow,
                                        input int lines);
    route_t ceiling;
    ceiling = narrow ? route_t'(lines - 2) : route_t'(lines - 1);
    return (r != '0) && (r != '1) && (r != route_t'(2)) && (r <= ceiling);
  endfunction

  // Nibble selection of the pin route bytes; bit positions are fixed.
  function automatic route_t pin_route(input int pin, input logic [7:0] b_a,
                                       input logic [7:0] b_bc,
                                       input logic [7:0] b_d);
    case (pin)
      0:       return {4'h0, b_a[7:4]};
      1:       return {4'h0, b_bc[3:0]};
      2:       return {4'h0, b_bc[7:4]};
      default: return {4'h0, b_d[7:4]};
    endcase
  endfunction
endpackage

// File: rtl/irq_rt_route_sel.sv
module irq_rt_route_sel
  import irq_rt_pkg::*;
#(
  parameter int NUM_FN     = 7,
  parameter int NUM_PINS   = 4,
  parameter int NSRC       = 12,
  parameter int NARROW_FN  = 'h2C
) (
  input  logic [8*NUM_FN-1:0]             fn_route,
  input  logic [7:0]                      pin_rt_a,
  input  logic [7:0]                      pin_rt_bc,
  input  logic [7:0]                      pin_rt_d,
  output logic [NSRC-1:0][ROUTE_W-1:0]    src_route,
  output logic [NSRC-1:0]                 src_narrow
);
  localparam int PIN_BASE = NUM_FN + 1;

  // Source 0 is the global slot and never routes anywhere.
  assign src_route[0]  = '0;
  assign src_narrow[0] = 1'b0;

  for (genvar f = 1; f <= NUM_FN; f++) begin : g_fn
    assign src_route[f]  = fn_route[8*(f-1) +: 8];
    assign src_narrow[f] = ((NARROW_FN >> f) & 1) != 0;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign src_route[PIN_BASE+p]  = pin_route(p, pin_rt_a, pin_rt_bc, pin_rt_d);
    assign src_narrow[PIN_BASE+p] = 1'b0;
  end
endmodule

// File: rtl/irq_rt_arbiter.sv
module irq_rt_arbiter #(
  parameter int NSRC = 12,
  parameter int SW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_lvl,
  output logic            fire,
  output logic [SW-1:0]   src_idx,
  output logic            src_new_lvl
);
  logic [NSRC-1:0] seen_q;
  logic [NSRC-1:0] pending;
  logic [NSRC-1:0] grant;

  assign pending = src_lvl ^ seen_q;
  assign fire    = |pending;

  // Lowest pending source wins.
  always_comb begin
    src_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending[i]) src_idx = SW'(i);
    end
  end

  assign grant       = fire ? (NSRC'(1) << src_idx) : '0;
  assign src_new_lvl = |(src_lvl & grant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_q ^ grant;
  end
endmodule

// File: rtl/irq_rt_mask_bank.sv
module irq_rt_mask_bank
  import irq_rt_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NSRC      = 12,
  parameter int SW        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [SW-1:0]        src_idx,
  input  logic                 src_new_lvl,
  input  route_t               route,
  input  logic                 route_ok,
  output logic [NSRC-1:0]      glob_q,
  output logic [NUM_LINES-1:0] line_q
);
  logic [NSRC-1:0] src_bit;
  logic [NSRC-1:0] glob_nx;

  assign src_bit = NSRC'(1) << src_idx;

  always_comb begin
    glob_nx = glob_q;
    if (fire) glob_nx = src_new_lvl ? (glob_q | src_bit) : (glob_q & ~src_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glob_q <= '0;
    else        glob_q <= glob_nx;
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] mask_nx;
    logic            hit;

    assign hit = fire && route_ok && (route == route_t'(l));

    always_comb begin
      mask_nx = mask_q;
      if (hit) begin
        mask_nx = src_new_lvl ? (mask_q | src_bit) : (mask_q & ~src_bit);
        mask_nx = mask_nx & glob_nx;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q    <= '0;
        line_q[l] <= 1'b0;
      end else begin
        mask_q    <= mask_nx;
        line_q[l] <= |mask_nx;
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_rt_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_FN    = 7,
  parameter int NUM_PINS  = 4,
  parameter int NARROW_FN = 'h2C
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PINS-1:0]    pin_lvl,
  input  logic [NUM_FN-1:0]      fn_lvl,
  input  logic [8*NUM_FN-1:0]    fn_route,
  input  logic [7:0]             pin_rt_a,
  input  logic [7:0]             pin_rt_bc,
  input  logic [7:0]             pin_rt_d,
  output logic [NUM_LINES-1:0]   irq_out
);
  localparam int PIN_BASE = NUM_FN + 1;
  localparam int NSRC     = PIN_BASE + NUM_PINS;
  localparam int SW       = $clog2(NSRC);

  logic [NSRC-1:0]              src_lvl;
  logic [NSRC-1:0][ROUTE_W-1:0] src_route;
  logic [NSRC-1:0]              src_narrow;

  // Named event wires, observed by the checker.
  logic            evt_fire;
  logic [SW-1:0]   evt_src;
  logic            evt_lvl;
  route_t          evt_route;
  logic            evt_hits;
  logic [NSRC-1:0] glob_q;

  assign src_lvl = {pin_lvl, fn_lvl, 1'b0};

  irq_rt_route_sel #(
    .NUM_FN(NUM_FN), .NUM_PINS(NUM_PINS), .NSRC(NSRC), .NARROW_FN(NARROW_FN)
  ) u_sel (
    .fn_route  (fn_route),
    .pin_rt_a  (pin_rt_a),
    .pin_rt_bc (pin_rt_bc),
    .pin_rt_d  (pin_rt_d),
    .src_route (src_route),
    .src_narrow(src_narrow)
  );

  irq_rt_arbiter #(.NSRC(NSRC), .SW(SW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_lvl    (src_lvl),
    .fire       (evt_fire),
    .src_idx    (evt_src),
    .src_new_lvl(evt_lvl)
  );

  assign evt_route = src_route[evt_src];
  assign evt_hits  = route_usable(evt_route, src_narrow[evt_src], NUM_LINES);

  irq_rt_mask_bank #(.NUM_LINES(NUM_LINES), .NSRC(NSRC), .SW(SW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (evt_fire),
    .src_idx    (evt_src),
    .src_new_lvl(evt_lvl),
    .route      (evt_route),
    .route_ok   (evt_hits),
    .glob_q     (glob_q),
    .line_q     (irq_out)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_LINES = 16,
  parameter int NSRC      = 12,
  parameter int SW        = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_out,
  input logic                 evt_fire,
  input logic [SW-1:0]        evt_src,
  input logic                 evt_lvl,
  input logic [7:0]           evt_route,
  input logic                 evt_hits,
  input logic [NSRC-1:0]      glob_q
);
  localparam int LW = $clog2(NUM_LINES);

  AST_LINE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out[0]); // R10

  AST_DROPPED_ROUTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fire && !evt_hits) |=> $stable(irq_out)); // R4

  AST_GLOBAL_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fire |=> (glob_q[$past(evt_src)] == $past(evt_lvl))); // R4

  AST_RAISE_REACHES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fire && evt_hits && evt_lvl) |=> irq_out[$past(evt_route[LW-1:0])]); // R6

  AST_QUIET_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_fire |=> $stable(irq_out)); // R9
endmodule

bind irq_router irq_router_chk #(
  .NUM_LINES(NUM_LINES), .NSRC(NSRC), .SW(SW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_out  (irq_out),
  .evt_fire (evt_fire),
  .evt_src  (evt_src),
  .evt_lvl  (evt_lvl),
  .evt_route(evt_route),
  .evt_hits (evt_hits),
  .glob_q   (glob_q)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin_lvl = '0;
  logic [6:0]  fn_lvl = '0;
  logic [55:0] fn_route = '0;
  logic [7:0]  pin_rt_a = 8'h50;
  logic [7:0]  pin_rt_bc = 8'hA9;
  logic [7:0]  pin_rt_d = 8'hB0;
  logic [15:0] irq_out;

  irq_router dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .fn_lvl(fn_lvl),
    .fn_route(fn_route), .pin_rt_a(pin_rt_a), .pin_rt_bc(pin_rt_bc),
    .pin_rt_d(pin_rt_d), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          due;
    logic [15:0] val;
    string       req;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare each expected word in its due cycle.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      checks++;
      if (irq_out !== sbq[0].val) begin
        fails++;
        $display("FAIL %s: irq_out=%h expected %h", sbq[0].req, irq_out, sbq[0].val);
      end
      void'(sbq.pop_front());
    end
  end

  task automatic push(input int k, input logic [15:0] v, input string r);
    exp_t e;
    e.due = cyc + k;
    e.val = v;
    e.req = r;
    sbq.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input logic [3:0] p, input logic [6:0] f,
                    input logic [15:0] e, input string r);
    @(negedge clk);
    pin_lvl = p;
    fn_lvl  = f;
    push(1, e, r);
    tick(2);
  endtask

  task automatic set_fr(input int n, input logic [7:0] v);
    fn_route[8*(n-1) +: 8] = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    set_fr(1, 8'd3);
    tick(3);
    rst_n = 1'b1;
    push(1, 16'h0000, "R1 reset state");
    tick(2);

    // R2: pin nibbles
    go(4'b0001, 7'h00, 16'h0020, "R2 pin A to 5");
    go(4'b0000, 7'h00, 16'h0000, "R2 pin A release");
    go(4'b0010, 7'h00, 16'h0200, "R2 pin B to 9");
    go(4'b0000, 7'h00, 16'h0000, "R2 pin B release");
    go(4'b0100, 7'h00, 16'h0400, "R2 pin C to 10");
    go(4'b0000, 7'h00, 16'h0000, "R2 pin C release");
    go(4'b1000, 7'h00, 16'h0800, "R2 pin D to 11");
    go(4'b0000, 7'h00, 16'h0000, "R2 pin D release");

    // R3: function route bytes
    go(4'b0000, 7'h01, 16'h0008, "R3 fn1 to 3");
    go(4'b0000, 7'h00, 16'h0000, "R3 fn1 release");
    set_fr(6, 8'd12);
    go(4'b0000, 7'h20, 16'h1000, "R3 fn6 to 12");
    go(4'b0000, 7'h00, 16'h0000, "R3 fn6 release");

    // R9: simultaneous changes served lowest source first, one per clock
    @(negedge clk);
    pin_lvl = 4'hF;
    fn_lvl  = 7'h01;
    push(1, 16'h0008, "R9 batch 1 fn1");
    push(2, 16'h0028, "R9 batch 2 pin A");
    push(3, 16'h0228, "R9 batch 3 pin B");
    push(4, 16'h0628, "R9 batch 4 pin C");
    push(5, 16'h0E28, "R9 batch 5 pin D");
    tick(6);
    @(negedge clk);
    pin_lvl = 4'h0;
    fn_lvl  = 7'h00;
    push(1, 16'h0E20, "R9 release 1");
    push(2, 16'h0E00, "R9 release 2");
    push(3, 16'h0C00, "R9 release 3");
    push(4, 16'h0800, "R9 release 4");
    push(5, 16'h0000, "R9 release 5");
    tick(6);

    // R6: sharing
    set_fr(1, 8'd5);
    go(4'b0001, 7'h00, 16'h0020, "R6 pin A on 5");
    go(4'b0001, 7'h01, 16'h0020, "R6 fn1 joins 5");
    go(4'b0000, 7'h01, 16'h0020, "R6 one sharer left");
    go(4'b0000, 7'h00, 16'h0000, "R6 all released");

    // R4: disabled routes
    set_fr(1, 8'h00);
    go(4'b0000, 7'h01, 16'h0000, "R4 R10 route 0");
    go(4'b0000, 7'h00, 16'h0000, "R4 route 0 release");
    set_fr(1, 8'hFF);
    go(4'b0000, 7'h01, 16'h0000, "R4 route FF");
    go(4'b0000, 7'h00, 16'h0000, "R4 route FF release");
    set_fr(1, 8'd6);
    set_fr(3, 8'd6);
    go(4'b0000, 7'h01, 16'h0040, "R4 fn1 on 6");
    set_fr(1, 8'h00);
    go(4'b0000, 7'h00, 16'h0040, "R4 disabled release leaves line");
    go(4'b0000, 7'h04, 16'h0040, "R4 fn3 on 6");
    go(4'b0000, 7'h00, 16'h0000, "R4 global updated by disabled event");

    // R5: illegal routes and ceilings
    set_fr(1, 8'd2);
    go(4'b0000, 7'h01, 16'h0000, "R5 route 2");
    go(4'b0000, 7'h00, 16'h0000, "R5 route 2 release");
    set_fr(1, 8'h10);
    go(4'b0000, 7'h01, 16'h0000, "R5 route 16");
    go(4'b0000, 7'h00, 16'h0000, "R5 route 16 release");
    set_fr(2, 8'd15);
    go(4'b0000, 7'h02, 16'h0000, "R5 fn2 ceiling 14");
    go(4'b0000, 7'h00, 16'h0000, "R5 fn2 release");
    set_fr(2, 8'd14);
    go(4'b0000, 7'h02, 16'h4000, "R5 fn2 on 14");
    go(4'b0000, 7'h00, 16'h0000, "R5 fn2 14 release");
    set_fr(4, 8'd15);
    go(4'b0000, 7'h08, 16'h8000, "R5 fn4 on 15");
    go(4'b0000, 7'h00, 16'h0000, "R5 fn4 release");
    pin_rt_d = 8'h20;
    go(4'b1000, 7'h00, 16'h0000, "R5 pin D route 2");
    go(4'b0000, 7'h00, 16'h0000, "R5 pin D release");
    pin_rt_bc = 8'hF9;
    go(4'b0100, 7'h00, 16'h8000, "R5 pin C on 15");
    go(4'b0000, 7'h00, 16'h0000, "R5 pin C release");

    // R8 / R7: stale bit after reroute, pruned by a later event
    pin_rt_a = 8'h50;
    set_fr(1, 8'd5);
    go(4'b0001, 7'h00, 16'h0020, "R8 pin A on 5");
    pin_rt_a = 8'h70;
    go(4'b0000, 7'h00, 16'h0020, "R8 stale line held");
    go(4'b0000, 7'h01, 16'h0020, "R7 fn1 on 5");
    go(4'b0000, 7'h00, 16'h0000, "R7 stale bit pruned");

    tick(2);
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule